// File: doc/BRIEF.md
# Peripheral Soft-Reset and Clock-Gate Sequencer

This block owns a small control word that a driver uses to put a neighbouring peripheral through a safe reset. The word carries two state bits: one that holds the peripheral in reset and one that stops its clock. Software changes them through a plain-write code, a set code (writes 1s) and a clear code (writes 0s), and reads both back at any time.

When the reset bit goes to 1, an internal counter holds the peripheral in reset for a fixed number of cycles. Once those cycles have passed, the hardware raises the gate bit by itself. Software polls for that bit as proof that the reset has finished. It then releases reset, clears the gate, and waits for the gate bit to read 0 again, which marks the clock running. While reset is held, the gate cannot be cleared, so a driver that gets the order wrong cannot restart the clock into a peripheral that is still in reset.

The peripheral's own logic is outside the block. It sees only the reset output and the clock-enable output.

Top module: `rstgate_ctrl`

## Requirements
- R1: With `wr_en` high and `wr_op` = 1 (set), each state bit whose position in `wr_data` holds 1 becomes 1 on the next clock edge. With `wr_op` = 2 (clear), each such bit becomes 0, except as limited by R6. A bit whose data position holds 0 is unchanged. The reset bit is at position 5 and the gate bit is at position 4.
- R2: With `wr_op` = 0 (plain write), both state bits load from positions 5 and 4 of `wr_data`, except as limited by R6. With `wr_op` = 3, or with `wr_en` low, neither bit changes, and no other data bit has any effect.
- R3: `rd_data` shows the reset bit at position 5 and the gate bit at position 4, with every other bit 0. It shows the new value in the cycle after the write edge.
- R4: If the reset bit has been 1 for 16 clock edges (HOLD) while the gate bit is 0, the gate bit becomes 1 on the 16th edge without any write. Before that edge it reads 0.
- R5: If the reset bit returns to 0 before HOLD edges have passed, the gate bit stays 0. The next assertion of reset starts a full new HOLD count.
- R6: A clear of the gate bit, through the clear code or the plain-write code, is ignored while the reset bit reads 1. This holds even when the same write also clears the reset bit.
- R7: `clk_en_o` is 0 exactly while the gate bit reads 1. `periph_rst_o` is 1 exactly while the reset bit reads 1.
- R8: While `rst_n` is low, both state bits are 0, `clk_en_o` is 1 and `periph_rst_o` is 0.
- R9: Once the reset bit reads 0, a clear of the gate bit takes effect on the next edge, and `clk_en_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Write code: 0 plain, 1 set, 2 clear, 3 no effect |
| wr_data | input | DATA_W | Write data; positions 5 and 4 are used |
| rd_data | output | DATA_W | Status readback |
| periph_rst_o | output | 1 | Reset to the peripheral |
| clk_en_o | output | 1 | Clock enable to the peripheral |

## Verification
The hardest case to reach from the ports is the edge where the hold count expires in the same cycle that software writes. A gate clear at that edge must lose to the automatic set, and a reset clear at that edge must still let the gate rise. The stimulus gets there by counting idle cycles after the reset-set write and issuing a clear on exactly the 16th edge. It also releases reset one edge early, at the 15th edge, to show that the count restarts from zero on the next assertion. The bench's reference model is compared with the ports on every cycle, so an off-by-one in the hold count shows up at once.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_NONE  = 2'd3
   } wr_op_e;

   typedef struct packed {
      logic rst_set;
      logic rst_clr;
      logic gate_set;
      logic gate_clr;
   } bit_ops_t;
endpackage

// File: rtl/rstgate_op_decode.sv
module rstgate_op_decode
   import rstgate_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RST_POS  = 5,
   parameter int GATE_POS = 4
) (
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [DATA_W-1:0] wr_data,
   output bit_ops_t          ops
);
   logic d_rst;
   logic d_gate;

   assign d_rst  = wr_data[RST_POS];
   assign d_gate = wr_data[GATE_POS];

   always_comb begin
      ops = '0;
      if (wr_en) begin
         unique case (wr_op_e'(wr_op))
            OP_WRITE: begin
               ops.rst_set  = d_rst;
               ops.rst_clr  = ~d_rst;
               ops.gate_set = d_gate;
               ops.gate_clr = ~d_gate;
            end
            OP_SET: begin
               ops.rst_set  = d_rst;
               ops.gate_set = d_gate;
            end
            OP_CLEAR: begin
               ops.rst_clr  = d_rst;
               ops.gate_clr = d_gate;
            end
            default: ops = '0;
         endcase
      end
   end
endmodule

// File: rtl/rstgate_seq.sv
module rstgate_seq
   import rstgate_pkg::*;
#(
   parameter int HOLD = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bit_ops_t ops,
   output logic     rst_q,
   output logic     gate_q
);
   localparam int CNT_W = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

   logic [CNT_W-1:0] cnt;
   logic             hold_done;

   assign hold_done = rst_q & ~gate_q & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q  <= 1'b0;
         gate_q <= 1'b0;
         cnt    <= '0;
      end else begin
         if (ops.rst_set)       rst_q <= 1'b1;
         else if (ops.rst_clr)  rst_q <= 1'b0;

         if (ops.gate_set || hold_done)    gate_q <= 1'b1;
         else if (ops.gate_clr && !rst_q)  gate_q <= 1'b0;

         if (!rst_q)       cnt <= '0;
         else if (!gate_q) cnt <= cnt + CNT_W'(1);
      end
   end

   // R1: a set request is visible on the following edge
   a_r1_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
      ops.rst_set |=> rst_q);

   // R4: an automatic gate rise only after the full hold count
   a_r4_no_early_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_q) && !$past(ops.gate_set)) |-> ($past(cnt) == LAST && $past(rst_q)));

   // R5: the counter restarts from zero whenever reset is released
   a_r5_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_q |=> (cnt == '0));

   // R6: the gate cannot drop while reset is held
   a_r6_gate_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q && gate_q) |=> gate_q);
endmodule

// File: rtl/rstgate_ctrl.sv
module rstgate_ctrl
   import rstgate_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int RST_POS       = 5,
   parameter int GATE_POS      = 4,
   parameter int HOLD          = 16,
   parameter bit RST_ACT_LOW   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              periph_rst_o,
   output logic              clk_en_o
);
   initial begin
      a_hold_min: assert (HOLD >= 16);
      a_pos_range: assert (RST_POS < DATA_W && GATE_POS < DATA_W);
      a_pos_distinct: assert (RST_POS != GATE_POS);
   end

   bit_ops_t ops;
   logic     rst_q;
   logic     gate_q;

   rstgate_op_decode #(
      .DATA_W(DATA_W), .RST_POS(RST_POS), .GATE_POS(GATE_POS)
   ) i_dec (
      .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data), .ops(ops)
   );

   rstgate_seq #(.HOLD(HOLD)) i_seq (
      .clk(clk), .rst_n(rst_n), .ops(ops), .rst_q(rst_q), .gate_q(gate_q)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[RST_POS]  = rst_q;
      rd_data[GATE_POS] = gate_q;
   end

   generate
      if (RST_ACT_LOW) begin : g_rst_low
         assign periph_rst_o = ~rst_q;
      end else begin : g_rst_high
         assign periph_rst_o = rst_q;
      end
   endgenerate

   assign clk_en_o = ~gate_q;

   // R3: a set write of the reset bit is visible in readback next cycle
   a_r3_readback_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'd1 && wr_data[RST_POS]) |=> rd_data[RST_POS]);

   // R9: a gate clear with reset low reopens the clock next cycle
   a_r9_ungate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'd2 && wr_data[GATE_POS] && !rd_data[RST_POS]
       && !wr_data[RST_POS]) |=> clk_en_o);
endmodule

// File: tb/test_rstgate_ctrl.sv
module test_rstgate_ctrl;
   localparam int DW = 8;
   localparam int HOLD = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_op = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          periph_rst_o;
   logic          clk_en_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rstgate_ctrl #(.DATA_W(DW), .HOLD(HOLD)) i_rstgate_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
      .wr_data(wr_data), .rd_data(rd_data),
      .periph_rst_o(periph_rst_o), .clk_en_o(clk_en_o)
   );

   // Behavioural reference: reset flag, gate flag, cycles spent in reset
   bit m_rst, m_gate;
   int m_held;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rst = 0; m_gate = 0; m_held = 0;
      end else begin
         bit s_r, c_r, s_g, c_g, n_rst, n_gate;
         s_r = 0; c_r = 0; s_g = 0; c_g = 0;
         if (wr_en) begin
            case (wr_op)
               2'd0: begin s_r = wr_data[5]; c_r = !wr_data[5];
                           s_g = wr_data[4]; c_g = !wr_data[4]; end
               2'd1: begin s_r = wr_data[5]; s_g = wr_data[4]; end
               2'd2: begin c_r = wr_data[5]; c_g = wr_data[4]; end
               default: ;
            endcase
         end
         n_rst = s_r ? 1'b1 : (c_r ? 1'b0 : m_rst);
         if (s_g || (m_rst && !m_gate && m_held + 1 >= HOLD)) n_gate = 1;
         else if (c_g && !m_rst) n_gate = 0;
         else n_gate = m_gate;
         if (!m_rst) m_held = 0;
         else if (!m_gate) m_held = m_held + 1;
         m_rst = n_rst;
         m_gate = n_gate;
      end
   end

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      check("R3 readback", rd_data, DW'({m_rst, m_gate}) << 4);
      check("R7 periph_rst", DW'(periph_rst_o), DW'(m_rst));
      check("R7 clk_en", DW'(clk_en_o), DW'(!m_gate));
   endtask

   task automatic step(input logic en, input logic [1:0] op, input logic [DW-1:0] d);
      wr_en = en; wr_op = op; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      compare_model();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      check("R8 reset state rd", rd_data, '0);
      check("R8 reset clk_en", DW'(clk_en_o), 1);
      check("R8 reset periph_rst", DW'(periph_rst_o), 0);
      rst_n = 1'b1;
      idle(2);

      // R4: set reset, gate rises on the 16th edge
      step(1, 2'd1, 8'h20);
      check("R1 rst set", DW'(rd_data[5]), 1);
      idle(HOLD - 1);
      check("R4 gate low before hold", DW'(rd_data[4]), 0);
      idle(1);
      check("R4 gate high after hold", DW'(rd_data[4]), 1);
      check("R7 clk_en low", DW'(clk_en_o), 0);

      // R6: gate clear ignored while reset held
      step(1, 2'd2, 8'h10);
      check("R6 gate kept", DW'(rd_data[4]), 1);
      // R6: plain write clearing both: reset drops, gate kept
      step(1, 2'd0, 8'h00);
      check("R6 combined clear", rd_data, 8'h10);
      // R9: now gate clear works
      step(1, 2'd2, 8'h10);
      check("R9 gate cleared", rd_data, 8'h00);
      check("R9 clk_en back", DW'(clk_en_o), 1);

      // R5: release one edge early, then full restart
      step(1, 2'd1, 8'h20);
      idle(HOLD - 2);
      step(1, 2'd2, 8'h20);
      idle(30);
      check("R5 no gate after early release", rd_data, 8'h00);
      step(1, 2'd1, 8'h20);
      idle(HOLD - 1);
      check("R5 full recount", DW'(rd_data[4]), 0);
      // Clear on the very edge the count expires: auto-set wins
      step(1, 2'd2, 8'h30);
      check("R4 expiry beats clear", rd_data, 8'h10);
      step(1, 2'd2, 8'h10);
      check("R9 ungate after race", rd_data, 8'h00);

      // R1/R2: software gate, code 3 and stray bits ignored
      step(1, 2'd1, 8'h10);
      check("R1 gate set by sw", rd_data, 8'h10);
      step(1, 2'd3, 8'hFF);
      check("R2 code 3 no effect", rd_data, 8'h10);
      step(1, 2'd1, 8'hCF);
      check("R2 stray bits ignored", rd_data, 8'h10);
      step(1, 2'd0, 8'h00);
      check("R2 plain write clears", rd_data, 8'h00);
      step(1, 2'd0, 8'h30);
      check("R2 plain write sets", rd_data, 8'h30);
      idle(4);

      // R8: hardware reset mid-sequence
      step(1, 2'd0, 8'h00);
      step(1, 2'd1, 8'h20);
      idle(3);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 hw reset clears", rd_data, 8'h00);
      check("R8 hw reset clk_en", DW'(clk_en_o), 1);
      rst_n = 1'b1;
      idle(3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule